// File: doc/BRIEF.md
# DDR Command Bus Protocol Monitor

This block watches a double-data-rate memory command bus passively. On each rising clock edge it samples chip select, the row strobe, the column strobe, write enable, clock enable, the bank select and the address bus. It decodes the command, reports it one cycle later, and keeps a model of four banks. For each bank the model holds whether the bank is idle or has a row open, and which row is open.

The model follows explicit precharge, auto-precharge at the end of a burst, refresh and self refresh. It uses these to enforce the ordering rules of the bus. A command that breaks a rule sets a sticky error bit, one bit per rule, and raises a one-cycle violation pulse. A timer checks that refresh commands arrive often enough.

The monitor is meant to sit beside a memory controller in simulation or in silicon debug. The bank state and the error flags come out as plain outputs.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: With cs_n high the cycle decodes as DESELECT, whatever the other strobes carry. With cs_n low, the bus nibble {cs_n,ras_n,cas_n,we_n} decodes as follows: 0011 ACTIVATE, 0101 READ, 0100 WRITE, 0010 PRECHARGE, 0001 REFRESH and 0000 MODE SET. Every other nibble is NOP. cmd_code shows the result one cycle after the edge, using these codes: 0 DESELECT, 1 NOP, 2 ACTIVATE, 3 READ, 4 WRITE, 5 PRECHARGE, 6 AUTO REFRESH, 7 SELF REFRESH, 8 MODE SET.
- R2: ACTIVATE to an idle bank marks bank ba as open (bank_open[ba]) and stores addr as its row in bank_row slice ba.
- R3: READ or WRITE to an idle bank sets err_flags[0] and leaves the bank state unchanged.
- R4: ACTIVATE to a bank that is already open sets err_flags[1] and keeps the stored row.
- R5: PRECHARGE with addr[10] low closes only bank ba. With addr[10] high it closes all banks and ba is ignored.
- R6: READ or WRITE with addr[10] high closes its bank N clock edges after the command edge. N is half the burst length. With addr[10] low the row stays open.
- R7: When a legal READ or WRITE arrives while an auto-precharge is still pending, the pending bank closes at the edge of that new command.
- R8: MODE SET while any bank is open, or while a burst is still running, sets err_flags[2]. Every MODE SET loads the burst length from addr[2:0]: 1 selects 2 beats, 2 selects 4 beats, 3 selects 8 beats, and any other value keeps the previous length. After reset the burst length is 4.
- R9: REFRESH with cke high is AUTO REFRESH and with cke low is SELF REFRESH. Either one while any bank is open sets err_flags[3].
- R10: After SELF REFRESH, every bus cycle is ignored and reported as DESELECT up to and including the first edge with cke high.
- R11: err_flags[4] sets at the REF_MAX-th consecutive edge without a refresh, and only once per gap. A spacing of exactly REF_MAX edges is legal. Reset, a refresh command and the self-refresh exit edge all restart the count, and edges spent in self refresh are not counted.
- R12: err_flags bits stay set until reset. violation is high for one cycle, in the same cycle that the flags show each new offending command or late refresh.
- R13: Reset leaves all banks idle, err_flags zero, violation low and cmd_code DESELECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable of the memory |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ROW_W | Address bus; bit 10 is the precharge qualifier |
| cmd_code | output | 4 | Decoded command of the previous edge |
| bank_open | output | 2**BA_W | One bit per bank, 1 when a row is open |
| bank_row | output | 2**BA_W*ROW_W | Open row per bank, bank 0 in the low slice |
| err_flags | output | 5 | Sticky errors: idle access, double activate, busy mode set, refresh while open, late refresh |
| violation | output | 1 | One-cycle pulse for each newly detected violation |

## Verification
The risky coincidence is an auto-precharge that is still pending when a new legal READ or WRITE reaches the bus. The pending bank must close on that same edge while the new burst starts on another bank. The bench provokes this with back-to-back reads to two open banks, the first with addr[10] high. It then expects only the second bank to remain open. The bench also places a MODE SET in the cycle after a precharge has closed the last open bank, with the burst still running, and expects the busy error from the running burst alone.

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor #(
  parameter int BA_W    = 2,
  parameter int ROW_W   = 14,
  parameter int REF_MAX = 1560
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cke,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic [BA_W-1:0]               ba,
  input  logic [ROW_W-1:0]              addr,
  output logic [3:0]                    cmd_code,
  output logic [(1<<BA_W)-1:0]          bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0]    bank_row,
  output logic [4:0]                    err_flags,
  output logic                          violation
);
  localparam int NB    = 1 << BA_W;
  localparam int REF_W = $clog2(REF_MAX + 1);
  localparam int AP    = 10;

  localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                         C_WR = 4'd4, C_PRE = 4'd5, C_AREF = 4'd6, C_SREF = 4'd7,
                         C_MRS = 4'd8;

  logic              in_sref, ap_pend;
  logic [2:0]        bl_clk, burst_cnt;
  logic [BA_W-1:0]   ap_bank;
  logic [REF_W-1:0]  ref_cnt;

  logic       live, open_sel, rw_ok, ap_close;
  logic       c_act, c_rd, c_wr, c_pre, c_ref, c_mrs, c_sref;
  logic [3:0] bus, code_d;
  logic [4:0] new_err;

  assign live     = ~in_sref;
  assign bus      = {cs_n, ras_n, cas_n, we_n};
  assign c_act    = live && bus == 4'b0011;
  assign c_rd     = live && bus == 4'b0101;
  assign c_wr     = live && bus == 4'b0100;
  assign c_pre    = live && bus == 4'b0010;
  assign c_ref    = live && bus == 4'b0001;
  assign c_mrs    = live && bus == 4'b0000;
  assign c_sref   = c_ref && !cke;
  assign open_sel = bank_open[ba];
  assign rw_ok    = (c_rd || c_wr) && open_sel;
  assign ap_close = ap_pend && (burst_cnt == 3'd1 || rw_ok);

  always_comb begin
    if (!live || cs_n) code_d = C_DES;
    else if (c_act)    code_d = C_ACT;
    else if (c_rd)     code_d = C_RD;
    else if (c_wr)     code_d = C_WR;
    else if (c_pre)    code_d = C_PRE;
    else if (c_ref)    code_d = cke ? C_AREF : C_SREF;
    else if (c_mrs)    code_d = C_MRS;
    else               code_d = C_NOP;
  end

  assign new_err[0] = (c_rd || c_wr) && !open_sel;
  assign new_err[1] = c_act && open_sel;
  assign new_err[2] = c_mrs && (|bank_open || burst_cnt != 3'd0);
  assign new_err[3] = c_ref && |bank_open;
  assign new_err[4] = live && !c_ref && ref_cnt == REF_W'(REF_MAX - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_code  <= C_DES;
      bank_open <= '0;
      bank_row  <= '0;
      err_flags <= '0;
      violation <= 1'b0;
      in_sref   <= 1'b0;
      ref_cnt   <= '0;
      bl_clk    <= 3'd2;
      burst_cnt <= '0;
      ap_pend   <= 1'b0;
      ap_bank   <= '0;
    end else begin
      cmd_code  <= code_d;
      err_flags <= err_flags | new_err;
      violation <= |new_err;

      if (in_sref && cke) in_sref <= 1'b0;
      else if (c_sref)    in_sref <= 1'b1;

      if (c_ref || in_sref)               ref_cnt <= '0;
      else if (ref_cnt != REF_W'(REF_MAX)) ref_cnt <= ref_cnt + 1'b1;

      if (c_mrs) begin
        case (addr[2:0])
          3'd1:    bl_clk <= 3'd1;
          3'd2:    bl_clk <= 3'd2;
          3'd3:    bl_clk <= 3'd4;
          default: bl_clk <= bl_clk;
        endcase
      end

      if (rw_ok)                    burst_cnt <= bl_clk;
      else if (burst_cnt != 3'd0)   burst_cnt <= burst_cnt - 1'b1;

      if (rw_ok) begin
        ap_pend <= addr[AP];
        ap_bank <= ba;
      end else if (ap_close) begin
        ap_pend <= 1'b0;
      end

      for (int i = 0; i < NB; i++) begin
        if (c_act && ba == BA_W'(i) && !bank_open[i]) begin
          bank_open[i] <= 1'b1;
          bank_row[i*ROW_W +: ROW_W] <= addr;
        end else if ((c_pre && (addr[AP] || ba == BA_W'(i))) ||
                     (ap_close && ap_bank == BA_W'(i))) begin
          bank_open[i] <= 1'b0;
        end
      end
    end
  end

  // R2
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_act && !open_sel |=> bank_open[$past(ba)]);

  // R3
  idle_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd || c_wr) && !open_sel |=> violation && err_flags[0]);

  // R5
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_pre && addr[AP] |=> bank_open == '0);

  // R8
  busy_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_mrs && |bank_open |=> err_flags[2] && violation);

  // R10
  sref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_sref |=> cmd_code == C_DES);

  // R12
  pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> err_flags != 5'd0);

  // R11
  late_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[4]) |-> violation);
endmodule

// File: tb/ddr_cmd_monitor_bench.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_bench;
  localparam int REF_LIM = 32;
  localparam logic [3:0] B_DES = 4'b1000, B_NOP = 4'b0111, B_ACT = 4'b0011,
                         B_RD = 4'b0101, B_WR = 4'b0100, B_PRE = 4'b0010,
                         B_REF = 4'b0001, B_MRS = 4'b0000;
  localparam logic [13:0] A10 = 14'h0400;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b0, cas_n = 1'b0, we_n = 1'b0;
  logic [1:0] ba = '0;
  logic [13:0] addr = '0;
  logic [3:0] cmd_code, bank_open;
  logic [55:0] bank_row;
  logic [4:0] err_flags;
  logic violation;

  int checks = 0, failures = 0;
  logic [4:0] exp_err = '0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [3:0] code;
    logic [3:0] open;
    logic [4:0] err;
    logic       viol;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ddr_cmd_monitor #(.BA_W(2), .ROW_W(14), .REF_MAX(REF_LIM)) u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code),
    .bank_open(bank_open), .bank_row(bank_row), .err_flags(err_flags),
    .violation(violation));

  always @(posedge clk) begin : monitor
    exp_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if ({cmd_code, bank_open, err_flags, violation} !== {it.code, it.open, it.err, it.viol}) begin
        failures++;
        $display("FAIL %s: actual code=%0d open=%b err=%b viol=%b expected code=%0d open=%b err=%b viol=%b",
                 it.tag, cmd_code, bank_open, err_flags, violation, it.code, it.open, it.err, it.viol);
      end
    end
  end

  task automatic step(input string tag, input logic [3:0] b, input logic [1:0] bk,
                      input logic [13:0] a, input logic ck, input logic [3:0] code,
                      input logic [3:0] open, input logic [4:0] ne);
    exp_t it;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = b;
    ba = bk; addr = a; cke = ck;
    exp_err = exp_err | ne;
    it.tag = tag; it.code = code; it.open = open; it.err = exp_err; it.viol = |ne;
    q.push_back(it);
    @(posedge clk);
    #2;
    {cs_n, ras_n, cas_n, we_n} = B_DES;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: actual run still busy expected finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 reset state", {violation, err_flags, bank_open, cmd_code}, '0);
    rst_n = 1'b1;

    step("R1 nop",            B_NOP, 0, 0, 1, 1, 4'b0000, 0);
    step("R1 deselect",       B_DES, 0, 0, 1, 0, 4'b0000, 0);
    step("R2 activate b1",    B_ACT, 1, 14'h1234, 1, 2, 4'b0010, 0);
    chk("R2 row b1", bank_row[14 +: 14], 14'h1234);
    step("R2 activate b2",    B_ACT, 2, 14'h0ABC, 1, 2, 4'b0110, 0);
    chk("R2 row b2", bank_row[28 +: 14], 14'h0ABC);
    step("R6 read no ap",     B_RD, 1, 0, 1, 3, 4'b0110, 0);
    step("R6 row stays",      B_NOP, 0, 0, 1, 1, 4'b0110, 0);
    step("R6 row stays",      B_NOP, 0, 0, 1, 1, 4'b0110, 0);
    step("R6 write ap",       B_WR, 2, A10, 1, 4, 4'b0110, 0);
    step("R6 ap wait",        B_NOP, 0, 0, 1, 1, 4'b0110, 0);
    step("R6 ap closes",      B_NOP, 0, 0, 1, 1, 4'b0010, 0);
    step("R3 read idle bank", B_RD, 3, 0, 1, 3, 4'b0010, 5'b00001);
    step("R4 double act",     B_ACT, 1, 14'h0001, 1, 2, 4'b0010, 5'b00010);
    chk("R4 row kept", bank_row[14 +: 14], 14'h1234);
    step("R8 mrs while open", B_MRS, 0, 0, 1, 8, 4'b0010, 5'b00100);
    step("R5 pre one",        B_PRE, 1, 0, 1, 5, 4'b0000, 0);
    step("R2 act b0",         B_ACT, 0, 14'h0005, 1, 2, 4'b0001, 0);
    step("R2 act b3",         B_ACT, 3, 14'h0007, 1, 2, 4'b1001, 0);
    step("R5 pre all",        B_PRE, 1, A10, 1, 5, 4'b0000, 0);
    step("R9 auto refresh",   B_REF, 0, 0, 1, 6, 4'b0000, 0);
    step("R2 act b0",         B_ACT, 0, 0, 1, 2, 4'b0001, 0);
    step("R9 refresh open",   B_REF, 0, 0, 1, 6, 4'b0001, 5'b01000);
    step("R5 pre b0",         B_PRE, 0, 0, 1, 5, 4'b0000, 0);
    step("R8 mrs legal bl8",  B_MRS, 0, 14'h0003, 1, 8, 4'b0000, 0);
    step("R2 act b2",         B_ACT, 2, 0, 1, 2, 4'b0100, 0);
    step("R6 read ap bl8",    B_RD, 2, A10, 1, 3, 4'b0100, 0);
    for (int i = 0; i < 3; i++) step("R8 bl8 wait", B_NOP, 0, 0, 1, 1, 4'b0100, 0);
    step("R8 bl8 closes",     B_NOP, 0, 0, 1, 1, 4'b0000, 0);
    step("R2 act b1",         B_ACT, 1, 0, 1, 2, 4'b0010, 0);
    step("R6 read b1",        B_RD, 1, 0, 1, 3, 4'b0010, 0);
    step("R5 pre b1",         B_PRE, 1, 0, 1, 5, 4'b0000, 0);
    step("R8 mrs in burst",   B_MRS, 0, 14'h0003, 1, 8, 4'b0000, 5'b00100);
    step("R9 refresh",        B_REF, 0, 0, 1, 6, 4'b0000, 0);
    step("R2 act b0",         B_ACT, 0, 0, 1, 2, 4'b0001, 0);
    step("R2 act b1",         B_ACT, 1, 0, 1, 2, 4'b0011, 0);
    step("R7 read b0 ap",     B_RD, 0, A10, 1, 3, 4'b0011, 0);
    step("R7 read b1 cuts",   B_RD, 1, 0, 1, 3, 4'b0010, 0);
    for (int i = 0; i < 3; i++) step("R7 b1 stays", B_NOP, 0, 0, 1, 1, 4'b0010, 0);
    step("R5 pre all",        B_PRE, 0, A10, 1, 5, 4'b0000, 0);
    step("R11 refresh",       B_REF, 0, 0, 1, 6, 4'b0000, 0);
    for (int i = 0; i < REF_LIM - 1; i++) step("R11 gap", B_NOP, 0, 0, 1, 1, 4'b0000, 0);
    step("R11 refresh at limit", B_REF, 0, 0, 1, 6, 4'b0000, 0);
    step("R9 self refresh",   B_REF, 0, 0, 0, 7, 4'b0000, 0);
    for (int i = 0; i < 3; i++) step("R10 ignored", B_ACT, 0, 0, 0, 0, 4'b0000, 0);
    step("R10 exit ignored",  B_ACT, 0, 0, 1, 0, 4'b0000, 0);
    step("R10 act after exit", B_ACT, 0, 0, 1, 2, 4'b0001, 0);
    for (int i = 0; i < REF_LIM - 2; i++) step("R11 gap", B_NOP, 0, 0, 1, 1, 4'b0001, 0);
    step("R11 late refresh",  B_NOP, 0, 0, 1, 1, 4'b0001, 5'b10000);
    step("R11 reported once", B_NOP, 0, 0, 1, 1, 4'b0001, 0);
    step("R12 flags sticky",  B_NOP, 0, 0, 1, 1, 4'b0001, 0);

    @(posedge clk);
    #3;
    chk("R12 queue drained", q.size(), 0);
    report();
    $finish;
  end
endmodule